// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits in front of a flash controller and decides, for every access request, whether it may proceed. An access carries a requester type, an access kind and a byte address. The address falls into one of five regions: main array, system memory, option bytes, backup registers or SRAM2. The decision combines three things: the current readout-protection level, two write-protect windows per main-array bank, and one execute-only window per bank. A mode input reports that a debugger is attached or that the device started from RAM or the loader. The answer comes back one cycle after the request.

The block owns the protection level register. Software requests level changes through a write strobe. Level 2 can never be left. A request to drop from level 1 to level 0 does not take effect at once. It starts a wipe sequence: backup registers are erased first, then SRAM2, and then, only if the wipe option was set, the execute-only area of each bank in turn. Each step is handed to the controller and held until the controller acknowledges it. The level falls to 0 only after the last step is acknowledged. Every refused access raises a one-cycle error pulse. The first refused address and requester are captured in a sticky status that a write-one-to-clear strobe empties.

Top module: `flash_guard`

## Requirements
- R1: Every cycle with `acc_valid` high gives `resp_valid` high on the following cycle, with `resp_allow` as the decision. A cycle without a request gives no response.
- R2: At level 0, requests to the main array outside all windows are allowed for every requester and kind. SRAM2 and backup register reads and writes are also allowed (requester codes: 0 fetch, 1 data, 2 DMA, 3 debug; kind codes: 0 read, 1 write, 2 erase).
- R3: At level 1 with `alt_mode` high, every access to the main array, backup registers and SRAM2 is denied, while option bytes accept read, write and erase. With `alt_mode` low at level 1, main-array writes are allowed.
- R4: System memory (address region field 1) allows reads only, at every level.
- R5: A write or erase to a main-array page inside an enabled write-protect window of its own bank is denied, and a read there is allowed. A window with low bound above high bound is disabled. Windows of the other bank have no effect.
- R6: Inside an enabled execute-only window of the addressed bank (double-word indices, inclusive), only a read by the fetch requester is allowed. Data, DMA and debug requests are denied there.
- R7: Level 2 is permanent: level writes are ignored once it is reached. At level 2 option bytes are read-only, the debug requester is always denied, and `alt_mode` has no effect.
- R8: A level write of 0 at level 1 starts a wipe in the order backup (code 0), SRAM2 (code 1), then the execute-only area (code 2) of bank 0, bank 1 and so on, with that part only when `xo_wipe_opt` was high at the start. Each step is held on `erase_busy`/`erase_what`/`erase_bank` until `erase_ack`. The level reads 1 until the last acknowledge and 0 on the next cycle.
- R9: While the wipe runs, every access is denied and level writes are ignored.
- R10: A denied response comes with a one-cycle `err_pulse` and sets `err_flag`. The first denied address and requester are captured and held until `err_clr`. A denial in the same cycle as `err_clr` is captured.
- R11: Unmapped regions (region field 5 to 7), erase of backup registers, a fetch requester with a write or erase kind, and kind code 3 are always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_src | input | 2 | Requester: 0 fetch, 1 data, 2 DMA, 3 debug |
| acc_kind | input | 2 | Kind: 0 read, 1 write, 2 erase |
| acc_addr | input | ADDR_W | Byte address; top 3 bits select the region |
| alt_mode | input | 1 | Debugger attached or boot from RAM/loader |
| wrp_lo | input | NUM_BANKS*2*PG_W | Write-protect window low page, per bank and window |
| wrp_hi | input | NUM_BANKS*2*PG_W | Write-protect window high page, inclusive |
| xo_lo | input | NUM_BANKS*DW_W | Execute-only window low double-word per bank |
| xo_hi | input | NUM_BANKS*DW_W | Execute-only window high double-word, inclusive |
| xo_wipe_opt | input | 1 | Wipe execute-only areas on regression |
| lvl_wr_en | input | 1 | Level change request strobe |
| lvl_wr_val | input | 2 | Requested level (0, 1, 2; 3 ignored) |
| erase_ack | input | 1 | Controller finished the current wipe step |
| err_clr | input | 1 | Write-one-to-clear for the error status |
| resp_valid | output | 1 | Decision present |
| resp_allow | output | 1 | Access allowed |
| err_pulse | output | 1 | One-cycle pulse on a denial |
| err_flag | output | 1 | Error status captured |
| err_addr | output | ADDR_W | Captured denied address |
| err_src | output | 2 | Captured denied requester |
| cur_level | output | 2 | Current protection level |
| erase_busy | output | 1 | Wipe step requested |
| erase_what | output | 2 | Wipe target: 0 backup, 1 SRAM2, 2 execute-only |
| erase_bank | output | BANK_W | Bank of an execute-only wipe step |

## Verification
The bench builds the block with 16-byte pages, 8 pages per bank and two banks. The main array is then 256 bytes and each bank holds 16 double words. Every page boundary, window edge and bank split can be reached with short literal addresses. Disabled windows and the other bank's windows are then tested next to enabled ones. The small bank count keeps the full wipe order, with both execute-only steps, to a handful of handshakes.

// File: rtl/fg_pkg.sv
// Shared encodings for the flash access protection checker.
// Assumes two-bit requester and kind codes and a three-bit region field.
package fg_pkg;
    typedef enum logic [1:0] {SRC_FETCH = 2'd0, SRC_DATA = 2'd1, SRC_DMA = 2'd2, SRC_DEBUG = 2'd3} src_e;
    typedef enum logic [1:0] {K_READ = 2'd0, K_WRITE = 2'd1, K_ERASE = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [2:0] {
        RG_MAIN = 3'd0, RG_SYS = 3'd1, RG_OPT = 3'd2, RG_BKP = 3'd3, RG_SRAM2 = 3'd4, RG_NONE = 3'd7
    } region_e;
    typedef enum logic [1:0] {WIPE_BKP = 2'd0, WIPE_SRAM2 = 2'd1, WIPE_XO = 2'd2} wipe_e;
    localparam logic [1:0] LVL0 = 2'd0;
    localparam logic [1:0] LVL1 = 2'd1;
    localparam logic [1:0] LVL2 = 2'd2;
endpackage

// File: rtl/fg_decode.sv
// Address decoder: splits a byte address into region, bank, page and double word.
// Assumes the main array fills the low MAIN_AW bits and the region code sits above it.
module fg_decode
    import fg_pkg::*;
#(
    parameter int MAIN_AW = 8,
    parameter int ADDR_W  = 11,
    parameter int BANK_W  = 1,
    parameter int PAGE_SH = 4,
    localparam int BANK_AW = MAIN_AW - BANK_W,
    localparam int PG_W    = BANK_AW - PAGE_SH,
    localparam int DW_W    = BANK_AW - 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [BANK_W-1:0] bank,
    output logic [PG_W-1:0]   page,
    output logic [DW_W-1:0]   dword
);
    assign bank  = addr[MAIN_AW-1 -: BANK_W];
    assign page  = addr[BANK_AW-1:PAGE_SH];
    assign dword = addr[BANK_AW-1:3];

    // Map the region field onto the region enumeration.
    always_comb begin
        case (addr[ADDR_W-1:MAIN_AW])
            3'd0:    region = RG_MAIN;
            3'd1:    region = RG_SYS;
            3'd2:    region = RG_OPT;
            3'd3:    region = RG_BKP;
            3'd4:    region = RG_SRAM2;
            default: region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/fg_window.sv
// Inclusive index window test; a window with low bound above high bound never hits.
module fg_window #(
    parameter int W = 4
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] idx,
    output logic         hit
);
    assign hit = (lo <= hi) && (idx >= lo) && (idx <= hi);
endmodule

// File: rtl/fg_policy.sv
// Combinational permission decision for one access.
// Assumes level is 0, 1 or 2 and that the window bounds are stable during the request.
module fg_policy
    import fg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    parameter int PG_W      = 3,
    parameter int DW_W      = 4
) (
    input  region_e                        region,
    input  logic [BANK_W-1:0]              bank,
    input  logic [PG_W-1:0]                page,
    input  logic [DW_W-1:0]                dword,
    input  src_e                           src,
    input  kind_e                          kind,
    input  logic [1:0]                     level,
    input  logic                           alt_mode,
    input  logic                           busy,
    input  logic [NUM_BANKS*2*PG_W-1:0]    wrp_lo,
    input  logic [NUM_BANKS*2*PG_W-1:0]    wrp_hi,
    input  logic [NUM_BANKS*DW_W-1:0]      xo_lo,
    input  logic [NUM_BANKS*DW_W-1:0]      xo_hi,
    output logic                           allow
);
    localparam int NWIN = NUM_BANKS * 2;

    logic [NWIN-1:0]      wrp_vec;
    logic [NUM_BANKS-1:0] xo_vec;
    logic                 wrp_hit;
    logic                 xo_hit;
    logic                 lvl2;
    logic                 locked;
    logic                 is_read;
    logic                 is_mod;

    for (genvar w = 0; w < NWIN; w++) begin : g_wrp
        fg_window #(.W(PG_W)) i_win (
            .lo (wrp_lo[w*PG_W +: PG_W]),
            .hi (wrp_hi[w*PG_W +: PG_W]),
            .idx(page),
            .hit(wrp_vec[w])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_xo
        fg_window #(.W(DW_W)) i_win (
            .lo (xo_lo[b*DW_W +: DW_W]),
            .hi (xo_hi[b*DW_W +: DW_W]),
            .idx(dword),
            .hit(xo_vec[b])
        );
    end

    // Keep only the window hits that belong to the addressed bank.
    always_comb begin
        wrp_hit = 1'b0;
        xo_hit  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_W'(b)) begin
                wrp_hit = wrp_hit | wrp_vec[2*b] | wrp_vec[2*b+1];
                xo_hit  = xo_hit | xo_vec[b];
            end
        end
    end

    assign lvl2    = (level == LVL2);
    assign locked  = (level == LVL1) && alt_mode;
    assign is_read = (kind == K_READ);
    assign is_mod  = (kind == K_WRITE) || (kind == K_ERASE);

    // Merge level, region and window rules into one allow bit.
    always_comb begin
        allow = 1'b0;
        if (busy || kind == K_RSVD) begin
            allow = 1'b0;
        end else if (lvl2 && src == SRC_DEBUG) begin
            allow = 1'b0;
        end else if (src == SRC_FETCH && !is_read) begin
            allow = 1'b0;
        end else begin
            case (region)
                RG_MAIN:  allow = !locked && !(is_mod && wrp_hit) && !(xo_hit && src != SRC_FETCH);
                RG_SYS:   allow = is_read;
                RG_OPT:   allow = lvl2 ? is_read : 1'b1;
                RG_BKP:   allow = !locked && (kind != K_ERASE);
                RG_SRAM2: allow = !locked;
                default:  allow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fg_level_seq.sv
// Protection level register and the level-1-to-0 wipe sequencer.
// Assumes erase_ack is only meaningful while a step is requested.
module fg_level_seq
    import fg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1,
    localparam int STEP_W   = $clog2(NUM_BANKS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_wr_en,
    input  logic [1:0]        lvl_wr_val,
    input  logic              xo_wipe_opt,
    input  logic              erase_ack,
    output logic [1:0]        level,
    output logic              busy,
    output logic [1:0]        what,
    output logic [BANK_W-1:0] bank
);
    logic [STEP_W-1:0] step;
    logic              wipe_xo;
    logic [STEP_W-1:0] last_step;

    assign last_step = wipe_xo ? STEP_W'(NUM_BANKS + 1) : STEP_W'(1);

    // Hold the level, accept legal changes and walk the wipe steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= LVL0;
            busy    <= 1'b0;
            step    <= '0;
            wipe_xo <= 1'b0;
        end else if (busy) begin
            if (erase_ack) begin
                if (step == last_step) begin
                    busy  <= 1'b0;
                    level <= LVL0;
                    step  <= '0;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end else if (lvl_wr_en && level != LVL2 && lvl_wr_val != 2'd3) begin
            if (level == LVL1 && lvl_wr_val == LVL0) begin
                busy    <= 1'b1;
                step    <= '0;
                wipe_xo <= xo_wipe_opt;
            end else begin
                level <= lvl_wr_val;
            end
        end
    end

    // Translate the step index into a target code and bank.
    always_comb begin
        if (step == STEP_W'(0)) begin
            what = WIPE_BKP;
            bank = '0;
        end else if (step == STEP_W'(1)) begin
            what = WIPE_SRAM2;
            bank = '0;
        end else begin
            what = WIPE_XO;
            bank = BANK_W'(step - STEP_W'(2));
        end
    end
endmodule

// File: rtl/flash_guard.sv
// Top of the flash access protection checker: registers the decision and error status.
// Assumes one request per cycle; the answer appears on the following cycle.
module flash_guard
    import fg_pkg::*;
#(
    parameter int PAGE_BYTES     = 2048,
    parameter int PAGES_PER_BANK = 256,
    parameter int NUM_BANKS      = 2,
    localparam int BANK_W  = $clog2(NUM_BANKS),
    localparam int PAGE_SH = $clog2(PAGE_BYTES),
    localparam int PG_W    = $clog2(PAGES_PER_BANK),
    localparam int MAIN_AW = PAGE_SH + PG_W + BANK_W,
    localparam int ADDR_W  = MAIN_AW + 3,
    localparam int DW_W    = PAGE_SH + PG_W - 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic [1:0]                  acc_src,
    input  logic [1:0]                  acc_kind,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic                        alt_mode,
    input  logic [NUM_BANKS*2*PG_W-1:0] wrp_lo,
    input  logic [NUM_BANKS*2*PG_W-1:0] wrp_hi,
    input  logic [NUM_BANKS*DW_W-1:0]   xo_lo,
    input  logic [NUM_BANKS*DW_W-1:0]   xo_hi,
    input  logic                        xo_wipe_opt,
    input  logic                        lvl_wr_en,
    input  logic [1:0]                  lvl_wr_val,
    input  logic                        erase_ack,
    input  logic                        err_clr,
    output logic                        resp_valid,
    output logic                        resp_allow,
    output logic                        err_pulse,
    output logic                        err_flag,
    output logic [ADDR_W-1:0]           err_addr,
    output logic [1:0]                  err_src,
    output logic [1:0]                  cur_level,
    output logic                        erase_busy,
    output logic [1:0]                  erase_what,
    output logic [BANK_W-1:0]           erase_bank
);
    region_e           region;
    logic [BANK_W-1:0] bank;
    logic [PG_W-1:0]   page;
    logic [DW_W-1:0]   dword;
    logic              allow;
    logic              deny_now;

    fg_decode #(
        .MAIN_AW(MAIN_AW), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_SH(PAGE_SH)
    ) i_decode (
        .addr  (acc_addr),
        .region(region),
        .bank  (bank),
        .page  (page),
        .dword (dword)
    );

    fg_policy #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .PG_W(PG_W), .DW_W(DW_W)
    ) i_policy (
        .region  (region),
        .bank    (bank),
        .page    (page),
        .dword   (dword),
        .src     (src_e'(acc_src)),
        .kind    (kind_e'(acc_kind)),
        .level   (cur_level),
        .alt_mode(alt_mode),
        .busy    (erase_busy),
        .wrp_lo  (wrp_lo),
        .wrp_hi  (wrp_hi),
        .xo_lo   (xo_lo),
        .xo_hi   (xo_hi),
        .allow   (allow)
    );

    fg_level_seq #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
    ) i_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_wr_en  (lvl_wr_en),
        .lvl_wr_val (lvl_wr_val),
        .xo_wipe_opt(xo_wipe_opt),
        .erase_ack  (erase_ack),
        .level      (cur_level),
        .busy       (erase_busy),
        .what       (erase_what),
        .bank       (erase_bank)
    );

    assign deny_now = acc_valid && !allow;

    // Register the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_allow <= acc_valid && allow;
            err_pulse  <= deny_now;
        end
    end

    // Capture the first denial; a new denial beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
            err_src  <= '0;
        end else if (deny_now && (!err_flag || err_clr)) begin
            err_flag <= 1'b1;
            err_addr <= acc_addr;
            err_src  <= acc_src;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fg_checker.sv
// Property checker for flash_guard, attached with bind.
module fg_checker #(
    parameter int ADDR_W  = 11,
    parameter int MAIN_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              alt_mode,
    input logic              resp_valid,
    input logic              resp_allow,
    input logic              err_flag,
    input logic [1:0]        cur_level,
    input logic              erase_busy
);
    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);
    a_r3_locked_main: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_level == 2'd1 && alt_mode && acc_addr[ADDR_W-1:MAIN_AW] == 3'd0) |=> !resp_allow);
    a_r4_sys_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[ADDR_W-1:MAIN_AW] == 3'd1 && acc_kind != 2'd0) |=> !resp_allow);
    a_r7_level2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == 2'd2) |=> (cur_level == 2'd2));
    a_r8_drop_needs_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == 2'd1 && !erase_busy) |=> (cur_level != 2'd0));
    a_r9_busy_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && acc_valid) |=> !resp_allow);
    a_r10_deny_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_allow) |-> err_flag);
endmodule

bind flash_guard fg_checker #(.ADDR_W(ADDR_W), .MAIN_AW(MAIN_AW)) i_chk (.*);

// File: tb/test_flash_guard.sv
// Directed bench for flash_guard with 16-byte pages, 8 pages per bank, 2 banks.
module test_flash_guard;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_src = '0;
    logic [1:0]    acc_kind = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          alt_mode = 1'b0;
    logic [11:0]   wrp_lo, wrp_hi;
    logic [7:0]    xo_lo, xo_hi;
    logic          xo_wipe_opt = 1'b0;
    logic          lvl_wr_en = 1'b0;
    logic [1:0]    lvl_wr_val = '0;
    logic          erase_ack = 1'b0;
    logic          err_clr = 1'b0;
    logic          resp_valid, resp_allow, err_pulse, err_flag;
    logic [AW-1:0] err_addr;
    logic [1:0]    err_src, cur_level, erase_what;
    logic          erase_busy;
    logic [0:0]    erase_bank;

    int n_run = 0;
    int n_fail = 0;
    logic last_allow, last_pulse, last_valid;

    flash_guard #(.PAGE_BYTES(16), .PAGES_PER_BANK(8), .NUM_BANKS(2)) i_flash_guard (.*);

    always #2.5 clk = ~clk;

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int rg, input int bk, input int off);
        return {rg[2:0], bk[0], off[6:0]};
    endfunction

    task automatic access(input int src, input int kind, input logic [AW-1:0] a, input logic clr = 1'b0);
        @(negedge clk);
        acc_valid = 1'b1; acc_src = src[1:0]; acc_kind = kind[1:0]; acc_addr = a; err_clr = clr;
        @(negedge clk);
        acc_valid = 1'b0; err_clr = 1'b0;
        last_valid = resp_valid; last_allow = resp_allow; last_pulse = err_pulse;
    endtask

    task automatic expect_acc(input string tag, input int src, input int kind,
                              input logic [AW-1:0] a, input logic exp);
        access(src, kind, a);
        chk({tag, " valid"}, 32'(last_valid), 32'd1);
        chk(tag, 32'(last_allow), 32'(exp));
        chk({tag, " pulse"}, 32'(last_pulse), 32'(!exp));
    endtask

    task automatic set_level(input int v);
        @(negedge clk);
        lvl_wr_en = 1'b1; lvl_wr_val = v[1:0];
        @(negedge clk);
        lvl_wr_en = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset resp_valid", 32'(resp_valid), 0);
        chk("R10 reset err_flag", 32'(err_flag), 0);
        chk("R8 reset level", 32'(cur_level), 0);
        chk("R8 reset busy", 32'(erase_busy), 0);
        @(negedge clk);
        chk("R1 idle no response", 32'(resp_valid), 0);
    endtask

    task automatic t_level0();
        expect_acc("R2 debug write main", 3, 1, mk(0, 0, 8'h10), 1'b1);
        expect_acc("R2 dma erase main", 2, 2, mk(0, 1, 8'h70), 1'b1);
        expect_acc("R2 dma write sram2", 2, 1, mk(4, 0, 8'h04), 1'b1);
        expect_acc("R2 data read backup", 1, 0, mk(3, 0, 8'h00), 1'b1);
        expect_acc("R11 backup erase", 1, 2, mk(3, 0, 8'h00), 1'b0);
        expect_acc("R11 unmapped region", 1, 0, mk(6, 0, 8'h00), 1'b0);
        expect_acc("R11 fetch write", 0, 1, mk(0, 0, 8'h10), 1'b0);
        expect_acc("R11 kind 3", 1, 3, mk(4, 0, 8'h00), 1'b0);
    endtask

    task automatic t_wrp();
        expect_acc("R5 write in window", 1, 1, mk(0, 0, 8'h20), 1'b0);
        expect_acc("R5 erase window top", 2, 2, mk(0, 0, 8'h3F), 1'b0);
        expect_acc("R5 read in window", 1, 0, mk(0, 0, 8'h20), 1'b1);
        expect_acc("R5 write above window", 1, 1, mk(0, 0, 8'h40), 1'b1);
        expect_acc("R5 write below window", 1, 1, mk(0, 0, 8'h1F), 1'b1);
        expect_acc("R5 bank1 window page0", 1, 1, mk(0, 1, 8'h00), 1'b0);
        expect_acc("R5 other bank ignores window", 1, 1, mk(0, 1, 8'h20), 1'b1);
        expect_acc("R5 disabled window", 1, 1, mk(0, 1, 8'h40), 1'b1);
    endtask

    task automatic t_xo();
        expect_acc("R6 fetch in xo", 0, 0, mk(0, 0, 8'h50), 1'b1);
        expect_acc("R6 data read in xo", 1, 0, mk(0, 0, 8'h58), 1'b0);
        expect_acc("R6 dma read in xo", 2, 0, mk(0, 0, 8'h50), 1'b0);
        expect_acc("R6 debug write in xo", 3, 1, mk(0, 0, 8'h5F), 1'b0);
        expect_acc("R6 data read past xo", 1, 0, mk(0, 0, 8'h60), 1'b1);
        expect_acc("R6 bank1 same offset", 1, 0, mk(0, 1, 8'h50), 1'b1);
    endtask

    task automatic t_sys();
        expect_acc("R4 sys read", 1, 0, mk(1, 0, 8'h08), 1'b1);
        expect_acc("R4 sys write", 3, 1, mk(1, 0, 8'h08), 1'b0);
        expect_acc("R4 sys erase", 2, 2, mk(1, 1, 8'h00), 1'b0);
    endtask

    task automatic t_level1();
        set_level(1);
        chk("R3 level now 1", 32'(cur_level), 1);
        alt_mode = 1'b1;
        expect_acc("R3 locked main read", 1, 0, mk(0, 0, 8'h70), 1'b0);
        expect_acc("R3 locked option write", 3, 1, mk(2, 0, 8'h00), 1'b1);
        expect_acc("R3 locked option erase", 3, 2, mk(2, 0, 8'h00), 1'b1);
        expect_acc("R3 locked backup read", 1, 0, mk(3, 0, 8'h00), 1'b0);
        expect_acc("R3 locked sram2 write", 2, 1, mk(4, 0, 8'h00), 1'b0);
        expect_acc("R4 locked sys read", 1, 0, mk(1, 0, 8'h00), 1'b1);
        alt_mode = 1'b0;
        expect_acc("R3 user main write", 1, 1, mk(0, 0, 8'h70), 1'b1);
    endtask

    task automatic t_err();
        clear_err();
        chk("R10 cleared", 32'(err_flag), 0);
        access(2, 1, mk(1, 0, 8'h11));
        chk("R10 flag set", 32'(err_flag), 1);
        chk("R10 addr captured", 32'(err_addr), 32'(mk(1, 0, 8'h11)));
        chk("R10 src captured", 32'(err_src), 2);
        access(3, 0, mk(7, 1, 8'h22));
        chk("R10 first kept addr", 32'(err_addr), 32'(mk(1, 0, 8'h11)));
        @(negedge clk);
        chk("R10 pulse one cycle", 32'(err_pulse), 0);
        access(1, 0, mk(5, 0, 8'h33), 1'b1);
        chk("R10 deny beats clear", 32'(err_addr), 32'(mk(5, 0, 8'h33)));
        chk("R10 deny beats clear flag", 32'(err_flag), 1);
        chk("R10 deny beats clear src", 32'(err_src), 1);
        clear_err();
        chk("R10 cleared again", 32'(err_flag), 0);
    endtask

    task automatic t_wipe(input logic wipe);
        int nstep;
        xo_wipe_opt = wipe;
        set_level(0);
        xo_wipe_opt = 1'b0;
        chk("R8 level held at 1", 32'(cur_level), 1);
        chk("R8 busy after drop", 32'(erase_busy), 1);
        expect_acc("R9 access during wipe", 1, 0, mk(4, 0, 8'h00), 1'b0);
        set_level(2);
        chk("R9 level write ignored", 32'(cur_level), 1);
        nstep = wipe ? 4 : 2;
        for (int i = 0; i < nstep; i++) begin
            chk("R8 step busy", 32'(erase_busy), 1);
            chk("R8 step target", 32'(erase_what), (i < 2) ? i : 2);
            if (i >= 2) chk("R8 step bank", 32'(erase_bank), i - 2);
            @(negedge clk);
            chk("R8 holds without ack", 32'(erase_what), (i < 2) ? i : 2);
            chk("R8 level during wipe", 32'(cur_level), 1);
            erase_ack = 1'b1;
            @(negedge clk);
            erase_ack = 1'b0;
        end
        chk("R8 done busy", 32'(erase_busy), 0);
        chk("R8 done level 0", 32'(cur_level), 0);
    endtask

    task automatic t_level2();
        set_level(2);
        chk("R7 level now 2", 32'(cur_level), 2);
        set_level(0);
        chk("R7 level stays 2", 32'(cur_level), 2);
        set_level(1);
        chk("R7 level stays 2 again", 32'(cur_level), 2);
        chk("R7 no wipe", 32'(erase_busy), 0);
        expect_acc("R7 debug read main", 3, 0, mk(0, 0, 8'h70), 1'b0);
        expect_acc("R7 option write", 1, 1, mk(2, 0, 8'h00), 1'b0);
        expect_acc("R7 option read", 1, 0, mk(2, 0, 8'h00), 1'b1);
        alt_mode = 1'b1;
        expect_acc("R7 alt_mode ignored main", 1, 0, mk(0, 0, 8'h70), 1'b1);
        expect_acc("R7 alt_mode ignored backup", 1, 1, mk(3, 0, 8'h00), 1'b1);
        alt_mode = 1'b0;
    endtask

    initial begin
        // bank0 win0 pages 2..3, bank0 win1 off, bank1 win0 page 0, bank1 win1 off (5>4)
        wrp_lo = {3'd5, 3'd0, 3'd7, 3'd2};
        wrp_hi = {3'd4, 3'd0, 3'd0, 3'd3};
        // bank0 execute-only double words 10..11, bank1 off
        xo_lo  = {4'd15, 4'd10};
        xo_hi  = {4'd0,  4'd11};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level0();
        t_wrp();
        t_xo();
        t_sys();
        t_level1();
        t_err();
        t_wipe(1'b1);
        set_level(1);
        t_wipe(1'b0);
        t_level2();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule